// File: doc/BRIEF.md
# Multi-queue almost-empty / almost-full status bus

This block turns the occupancy counts of a set of queues into programmable near-empty and near-full status. The queues are arranged in groups of equal size. Each queue is judged against a fixed empty offset and a fixed full offset. The read side reports near-empty status and runs on the read clock. The write side reports near-full status and runs on the write clock. Each side drives three things: a single active-low flag for the queue currently selected on that port, an active-low status bus one group wide, and a bus-enable output. The bus-enable output stands in for the tri-state control a pad would have.

A mode input is captured while master reset is held, and it sets how both status buses behave. In direct mode, a strobe picks the group to show. The group is taken from the queue address presented with the strobe, and the bus then tracks the live status of that group. In polled mode, the bus moves on to the next group at every clock edge and wraps after the last group. A group index output always names the group the bus is showing. A strobe must never share a cycle with a queue-change (address-enable) cycle. If the two coincide, the strobe is dropped and a one-cycle error pulse is raised.

Top module: `qflag_bus`

## Requirements
- R1: On every read clock edge, `rd_ae_n` takes the value 0 if the occupancy of the selected read queue is at or below `EMPTY_OFF`, and 1 otherwise. A change in occupancy therefore shows one read edge later.
- R2: On every write clock edge, `wr_af_n` takes the value 0 if `DEPTH` minus the occupancy of the selected write queue is at or below `FULL_OFF`, and 1 otherwise.
- R3: When the address enable is high on an edge, the address is loaded as the selected queue, provided it is below `NUM_GROUPS*GROUP_Q`. An address at or above that limit leaves the selection unchanged. The flag follows the new queue from the next edge.
- R4: `flag_mode` is sampled only while `mrst_n` is low: 0 gives direct mode and 1 gives polled mode. A change of `flag_mode` after reset has no effect.
- R5: In direct mode, an accepted strobe selects group `addr / GROUP_Q`. From the next edge on, `*_grp` equals that group and bit i of the bus is the active-low status of queue `group*GROUP_Q + i`. The bus is refreshed on every edge until another strobe is accepted.
- R6: A direct-mode strobe whose address maps to a group at or above `NUM_GROUPS` is ignored.
- R7: If the strobe and the address enable are high on the same edge, the strobe is ignored, and `*_clash` is 1 for exactly the following cycle. The queue selection still takes place.
- R8: In polled mode, the first edge after reset shows group 0. Each later edge shows the next group, wrapping from `NUM_GROUPS-1` to 0. Strobes have no effect.
- R9: The bus enable is 0 after reset and the bus reads all ones while the enable is 0. The enable rises with the first accepted strobe in direct mode, or at the first edge after reset in polled mode. It stays high until the next reset.
- R10: While `mrst_n` is low, both flags are 1, both buses are all ones, both group indices are 0, and both clash pulses and both bus enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mrst_n | input | 1 | Master reset, active low, synchronous to each clock |
| flag_mode | input | 1 | Mode sampled during reset: 0 direct, 1 polled |
| rclk | input | 1 | Read clock |
| occ_rd | input | NUM_GROUPS*GROUP_Q*CW | Queue occupancies as seen by the read side, queue 0 in the low bits |
| rd_addr | input | QA | Read queue address, also the group source for the read strobe |
| rd_addr_en | input | 1 | Read queue change enable |
| rd_strobe | input | 1 | Read-side status strobe (direct mode) |
| rd_ae_n | output | 1 | Near-empty flag of the selected read queue, active low |
| rd_bus_n | output | GROUP_Q | Near-empty status of the shown group, active low |
| rd_bus_oe | output | 1 | Read status bus enable |
| rd_grp | output | GA | Group shown on the read status bus |
| rd_clash | output | 1 | One-cycle pulse on strobe/address-enable collision |
| wclk | input | 1 | Write clock |
| occ_wr | input | NUM_GROUPS*GROUP_Q*CW | Queue occupancies as seen by the write side |
| wr_addr | input | QA | Write queue address, also the group source for the write strobe |
| wr_addr_en | input | 1 | Write queue change enable |
| wr_strobe | input | 1 | Write-side status strobe (direct mode) |
| wr_af_n | output | 1 | Near-full flag of the selected write queue, active low |
| wr_bus_n | output | GROUP_Q | Near-full status of the shown group, active low |
| wr_bus_oe | output | 1 | Write status bus enable |
| wr_grp | output | GA | Group shown on the write status bus |
| wr_clash | output | 1 | One-cycle pulse on strobe/address-enable collision |

## Verification
The bench builds the block with three groups of four queues, a depth of 16, an empty offset of 3 and a full offset of 5. Because of the small depth, every occupancy value from 0 to 16 can be swept on every one of the twelve queues on both sides. The group count is not a power of two, so the polled wrap from group 2 back to 0 is exercised, and the four-bit addresses 12 to 15 give both invalid queue selections and strobes to a group that does not exist.

// File: rtl/qflag_pkg.sv
`timescale 1ns/1ps
package qflag_pkg;

  // Near-empty: occupancy does not exceed the empty offset.
  function automatic logic near_empty(input int unsigned occ, input int unsigned off);
    return occ <= off;
  endfunction

  // Near-full: free slots do not exceed the full offset (saturates on overfill).
  function automatic logic near_full(input int unsigned occ, input int unsigned depth,
                                     input int unsigned off);
    if (occ >= depth) return 1'b1;
    return (depth - occ) <= off;
  endfunction

  // Sequential group stepping with wrap.
  function automatic int unsigned next_group(input int unsigned g, input int unsigned n);
    return (g + 1 >= n) ? 0 : g + 1;
  endfunction

  // Group a queue address belongs to.
  function automatic int unsigned group_of(input int unsigned addr, input int unsigned per);
    return addr / per;
  endfunction

endpackage

// File: rtl/qflag_eval.sv
`timescale 1ns/1ps
module qflag_eval #(
  parameter int TOTAL     = 16,
  parameter int CW        = 9,
  parameter int DEPTH     = 256,
  parameter int OFFSET    = 8,
  parameter bit FULL_SIDE = 1'b0
) (
  input  logic [TOTAL*CW-1:0] occ_flat,
  output logic [TOTAL-1:0]    hit
);
  import qflag_pkg::*;

  for (genvar i = 0; i < TOTAL; i++) begin : g_q
    logic [CW-1:0] occ_i;
    assign occ_i = occ_flat[i*CW +: CW];
    if (FULL_SIDE) begin : g_full
      assign hit[i] = near_full(32'(occ_i), DEPTH, OFFSET);
    end else begin : g_empty
      assign hit[i] = near_empty(32'(occ_i), OFFSET);
    end
  end

endmodule

// File: rtl/qflag_port.sv
`timescale 1ns/1ps
module qflag_port #(
  parameter int TOTAL      = 16,
  parameter int GROUP_Q    = 4,
  parameter int NUM_GROUPS = 4,
  parameter int QA         = 4,
  parameter int GA         = 2
) (
  input  logic               clk,
  input  logic               mrst_n,
  input  logic               flag_mode,
  input  logic [TOTAL-1:0]   hit,
  input  logic [QA-1:0]      addr,
  input  logic               addr_en,
  input  logic               strobe,
  output logic               flag_n,
  output logic [GROUP_Q-1:0] bus_n,
  output logic               bus_oe,
  output logic [GA-1:0]      grp,
  output logic               clash
);
  import qflag_pkg::*;

  logic               mode_q;    // 1 = polled
  logic [QA-1:0]      sel_q;
  logic [GA-1:0]      grp_q;
  logic               oe_q;
  logic [GROUP_Q-1:0] bus_q;
  logic               flag_q;
  logic               clash_q;

  // Named events for the assertions
  logic               sel_load;
  logic               collide;
  logic               strobe_take;
  int unsigned        addr_grp;
  logic [GA-1:0]      grp_nxt;
  logic               oe_nxt;
  logic [GROUP_Q-1:0] slice_hit;

  always_comb begin
    addr_grp    = group_of(32'(addr), GROUP_Q);
    sel_load    = addr_en && (32'(addr) < TOTAL);
    collide     = strobe && addr_en;
    strobe_take = !mode_q && strobe && !addr_en && (addr_grp < NUM_GROUPS);
    if (mode_q) begin
      grp_nxt = oe_q ? GA'(next_group(32'(grp_q), NUM_GROUPS)) : '0;
      oe_nxt  = 1'b1;
    end else begin
      grp_nxt = strobe_take ? GA'(addr_grp) : grp_q;
      oe_nxt  = oe_q || strobe_take;
    end
    slice_hit = hit[int'(grp_nxt)*GROUP_Q +: GROUP_Q];
  end

  always_ff @(posedge clk) begin
    if (!mrst_n) begin
      mode_q  <= flag_mode;
      sel_q   <= '0;
      grp_q   <= '0;
      oe_q    <= 1'b0;
      bus_q   <= '1;
      flag_q  <= 1'b1;
      clash_q <= 1'b0;
    end else begin
      if (sel_load) sel_q <= addr;
      grp_q   <= grp_nxt;
      oe_q    <= oe_nxt;
      bus_q   <= oe_nxt ? ~slice_hit : '1;
      flag_q  <= ~hit[sel_q];
      clash_q <= collide;
    end
  end

  assign flag_n = flag_q;
  assign bus_n  = bus_q;
  assign bus_oe = oe_q;
  assign grp    = grp_q;
  assign clash  = clash_q;

  AST_MODE_LATCHED: assert property (@(posedge clk) disable iff (!mrst_n)
    $past(mrst_n) |-> $stable(mode_q)); // R4
  AST_SEL_RANGE: assert property (@(posedge clk) disable iff (!mrst_n)
    32'(sel_q) < TOTAL); // R3
  AST_BAD_ADDR_KEEPS_SEL: assert property (@(posedge clk) disable iff (!mrst_n)
    (addr_en && !sel_load) |=> $stable(sel_q)); // R3
  AST_DIRECT_IDLE_HOLD: assert property (@(posedge clk) disable iff (!mrst_n)
    (!mode_q && !strobe) |=> $stable(grp)); // R5
  AST_GRP_RANGE: assert property (@(posedge clk) disable iff (!mrst_n)
    32'(grp) < NUM_GROUPS); // R6
  AST_CLASH_PULSE: assert property (@(posedge clk) disable iff (!mrst_n)
    (strobe && addr_en) |=> clash); // R7
  AST_NO_SPURIOUS_CLASH: assert property (@(posedge clk) disable iff (!mrst_n)
    !(strobe && addr_en) |=> !clash); // R7
  AST_CLASH_KEEPS_GROUP: assert property (@(posedge clk) disable iff (!mrst_n)
    (!mode_q && strobe && addr_en) |=> $stable(grp)); // R7
  AST_POLL_WRAP: assert property (@(posedge clk) disable iff (!mrst_n)
    (mode_q && oe_q && 32'(grp_q) == NUM_GROUPS - 1) |=> grp == '0); // R8
  AST_OE_STICKY: assert property (@(posedge clk) disable iff (!mrst_n)
    bus_oe |=> bus_oe); // R9
  AST_IDLE_BUS_ONES: assert property (@(posedge clk) disable iff (!mrst_n)
    !bus_oe |-> bus_n == '1); // R9

endmodule

// File: rtl/qflag_bus.sv
`timescale 1ns/1ps
module qflag_bus #(
  parameter int NUM_GROUPS = 4,
  parameter int GROUP_Q    = 4,
  parameter int DEPTH      = 256,
  parameter int EMPTY_OFF  = 8,
  parameter int FULL_OFF   = 8,
  localparam int TOTAL     = NUM_GROUPS * GROUP_Q,
  localparam int CW        = $clog2(DEPTH + 1),
  localparam int QA        = (TOTAL > 1) ? $clog2(TOTAL) : 1,
  localparam int GA        = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
  input  logic               mrst_n,
  input  logic               flag_mode,
  input  logic               rclk,
  input  logic [TOTAL*CW-1:0] occ_rd,
  input  logic [QA-1:0]      rd_addr,
  input  logic               rd_addr_en,
  input  logic               rd_strobe,
  output logic               rd_ae_n,
  output logic [GROUP_Q-1:0] rd_bus_n,
  output logic               rd_bus_oe,
  output logic [GA-1:0]      rd_grp,
  output logic               rd_clash,
  input  logic               wclk,
  input  logic [TOTAL*CW-1:0] occ_wr,
  input  logic [QA-1:0]      wr_addr,
  input  logic               wr_addr_en,
  input  logic               wr_strobe,
  output logic               wr_af_n,
  output logic [GROUP_Q-1:0] wr_bus_n,
  output logic               wr_bus_oe,
  output logic [GA-1:0]      wr_grp,
  output logic               wr_clash
);

  logic [TOTAL-1:0] empty_hit;
  logic [TOTAL-1:0] full_hit;

  qflag_eval #(.TOTAL(TOTAL), .CW(CW), .DEPTH(DEPTH), .OFFSET(EMPTY_OFF),
               .FULL_SIDE(1'b0)) u_eval_rd (
    .occ_flat (occ_rd),
    .hit      (empty_hit)
  );

  qflag_eval #(.TOTAL(TOTAL), .CW(CW), .DEPTH(DEPTH), .OFFSET(FULL_OFF),
               .FULL_SIDE(1'b1)) u_eval_wr (
    .occ_flat (occ_wr),
    .hit      (full_hit)
  );

  qflag_port #(.TOTAL(TOTAL), .GROUP_Q(GROUP_Q), .NUM_GROUPS(NUM_GROUPS),
               .QA(QA), .GA(GA)) u_port_rd (
    .clk       (rclk),
    .mrst_n    (mrst_n),
    .flag_mode (flag_mode),
    .hit       (empty_hit),
    .addr      (rd_addr),
    .addr_en   (rd_addr_en),
    .strobe    (rd_strobe),
    .flag_n    (rd_ae_n),
    .bus_n     (rd_bus_n),
    .bus_oe    (rd_bus_oe),
    .grp       (rd_grp),
    .clash     (rd_clash)
  );

  qflag_port #(.TOTAL(TOTAL), .GROUP_Q(GROUP_Q), .NUM_GROUPS(NUM_GROUPS),
               .QA(QA), .GA(GA)) u_port_wr (
    .clk       (wclk),
    .mrst_n    (mrst_n),
    .flag_mode (flag_mode),
    .hit       (full_hit),
    .addr      (wr_addr),
    .addr_en   (wr_addr_en),
    .strobe    (wr_strobe),
    .flag_n    (wr_af_n),
    .bus_n     (wr_bus_n),
    .bus_oe    (wr_bus_oe),
    .grp       (wr_grp),
    .clash     (wr_clash)
  );

endmodule

// File: tb/tb_qflag_bus.sv
`timescale 1ns/1ps
module tb_qflag_bus;
  localparam int NG = 3, GQ = 4, DEP = 16, EOFF = 3, FOFF = 5;
  localparam int TOT = NG * GQ, CW = 5, QA = 4, GA = 2;

  logic mrst_n = 1'b0, flag_mode = 1'b0;
  logic rclk = 1'b0, wclk = 1'b0;
  logic [TOT*CW-1:0] occ_rd, occ_wr;
  logic [QA-1:0] rd_addr = '0, wr_addr = '0;
  logic rd_addr_en = 0, rd_strobe = 0, wr_addr_en = 0, wr_strobe = 0;
  logic rd_ae_n, rd_bus_oe, rd_clash, wr_af_n, wr_bus_oe, wr_clash;
  logic [GQ-1:0] rd_bus_n, wr_bus_n;
  logic [GA-1:0] rd_grp, wr_grp;

  int occr [TOT];
  int occw [TOT];
  int errs = 0, checks = 0;
  bit done = 0;

  always #2.5 rclk = ~rclk;
  initial begin #1.25; forever #2.5 wclk = ~wclk; end

  always_comb begin
    for (int i = 0; i < TOT; i++) begin
      occ_rd[i*CW +: CW] = CW'(occr[i]);
      occ_wr[i*CW +: CW] = CW'(occw[i]);
    end
  end

  qflag_bus #(.NUM_GROUPS(NG), .GROUP_Q(GQ), .DEPTH(DEP), .EMPTY_OFF(EOFF),
              .FULL_OFF(FOFF)) dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rtick(); @(posedge rclk); #1; endtask
  task automatic wtick(); @(posedge wclk); #1; endtask

  function automatic int e_bit(input int v); return (v <= EOFF) ? 0 : 1; endfunction
  function automatic int f_bit(input int v); return (v + FOFF >= DEP) ? 0 : 1; endfunction

  function automatic int exp_rbus(input int g);
    int r = 0;
    for (int i = 0; i < GQ; i++) r |= e_bit(occr[g*GQ+i]) << i;
    return r;
  endfunction
  function automatic int exp_wbus(input int g);
    int r = 0;
    for (int i = 0; i < GQ; i++) r |= f_bit(occw[g*GQ+i]) << i;
    return r;
  endfunction

  task automatic fill(input int p);
    for (int i = 0; i < TOT; i++) begin
      occr[i] = (i*5 + p*3) % (DEP+1);
      occw[i] = (i*7 + p*5) % (DEP+1);
    end
  endtask

  initial begin
    for (int i = 0; i < TOT; i++) begin occr[i] = 0; occw[i] = 0; end
    repeat (3) rtick();
    // R10 reset state
    chk("R10 rd_ae_n", rd_ae_n, 1);     chk("R10 wr_af_n", wr_af_n, 1);
    chk("R10 rd_bus_n", rd_bus_n, 15);  chk("R10 wr_bus_n", wr_bus_n, 15);
    chk("R10 rd_grp", rd_grp, 0);       chk("R10 wr_grp", wr_grp, 0);
    chk("R10 rd_oe", rd_bus_oe, 0);     chk("R10 wr_oe", wr_bus_oe, 0);
    chk("R10 rd_clash", rd_clash, 0);   chk("R10 wr_clash", wr_clash, 0);
    mrst_n = 1'b1;

    // R1 + R3: every queue, every occupancy, read side
    for (int q = 0; q < TOT; q++) begin
      rd_addr = QA'(q); rd_addr_en = 1; rtick(); rd_addr_en = 0;
      for (int v = 0; v <= DEP; v++) begin
        for (int i = 0; i < TOT; i++) occr[i] = (v <= EOFF) ? DEP : 0;
        occr[q] = v;
        rtick();
        chk("R1 rd_ae_n sweep", rd_ae_n, e_bit(v));
      end
    end
    // R3: out-of-range address keeps queue 11 selected
    rd_addr = 4'd13; rd_addr_en = 1; rtick(); rd_addr_en = 0;
    for (int i = 0; i < TOT; i++) occr[i] = DEP;
    occr[11] = 0;
    rtick(); rtick();
    chk("R3 rd bad address ignored", rd_ae_n, 0);

    // R2 + R3: write side
    for (int q = 0; q < TOT; q++) begin
      wr_addr = QA'(q); wr_addr_en = 1; wtick(); wr_addr_en = 0;
      for (int v = 0; v <= DEP; v++) begin
        for (int i = 0; i < TOT; i++) occw[i] = (f_bit(v) == 0) ? 0 : DEP;
        occw[q] = v;
        wtick();
        chk("R2 wr_af_n sweep", wr_af_n, f_bit(v));
      end
    end
    wr_addr = 4'd15; wr_addr_en = 1; wtick(); wr_addr_en = 0;
    for (int i = 0; i < TOT; i++) occw[i] = 0;
    occw[11] = DEP;
    wtick(); wtick();
    chk("R3 wr bad address ignored", wr_af_n, 0);

    // R9: no strobe yet, bus disabled and all ones; R4: late mode change ignored
    chk("R9 rd oe idle", rd_bus_oe, 0); chk("R9 rd bus idle", rd_bus_n, 15);
    flag_mode = 1'b1;
    repeat (4) rtick();
    chk("R4 rd no polling after late mode change", rd_grp, 0);
    chk("R4 rd oe stays low", rd_bus_oe, 0);
    chk("R4 wr oe stays low", wr_bus_oe, 0);
    flag_mode = 1'b0;

    // R5 direct mode read side
    for (int p = 0; p < 4; p++) begin
      fill(p);
      for (int g = 0; g < NG; g++) begin
        rd_addr = QA'(g*GQ + p); rd_strobe = 1; rtick(); rd_strobe = 0;
        chk("R5 rd grp", rd_grp, g);
        chk("R5 rd bus", rd_bus_n, exp_rbus(g));
        chk("R9 rd oe", rd_bus_oe, 1);
        for (int i = 0; i < TOT; i++) occr[i] = DEP - occr[i];
        rtick();
        chk("R5 rd bus tracks", rd_bus_n, exp_rbus(g));
      end
    end
    // R6: strobe to nonexistent group
    rd_addr = 4'd12; rd_strobe = 1; rtick(); rd_strobe = 0;
    chk("R6 rd grp kept", rd_grp, 2);
    chk("R6 rd bus kept group", rd_bus_n, exp_rbus(2));
    // R7: strobe with address enable
    fill(1);
    rd_addr = 4'd1; rd_strobe = 1; rd_addr_en = 1; rtick();
    rd_strobe = 0; rd_addr_en = 0;
    chk("R7 rd clash pulse", rd_clash, 1);
    chk("R7 rd grp kept", rd_grp, 2);
    rtick();
    chk("R7 rd clash ends", rd_clash, 0);
    chk("R7 rd queue still selected", rd_ae_n, e_bit(occr[1]));

    // R5 R6 R7 write side
    for (int p = 0; p < 3; p++) begin
      fill(p);
      for (int g = 0; g < NG; g++) begin
        wr_addr = QA'(g*GQ + 3 - p); wr_strobe = 1; wtick(); wr_strobe = 0;
        chk("R5 wr grp", wr_grp, g);
        chk("R5 wr bus", wr_bus_n, exp_wbus(g));
        chk("R9 wr oe", wr_bus_oe, 1);
      end
    end
    wr_addr = 4'd14; wr_strobe = 1; wtick(); wr_strobe = 0;
    chk("R6 wr grp kept", wr_grp, 2);
    wr_addr = 4'd5; wr_strobe = 1; wr_addr_en = 1; wtick();
    wr_strobe = 0; wr_addr_en = 0;
    chk("R7 wr clash pulse", wr_clash, 1);
    chk("R7 wr grp kept", wr_grp, 2);
    wtick();
    chk("R7 wr clash ends", wr_clash, 0);
    chk("R7 wr queue still selected", wr_af_n, f_bit(occw[5]));

    // R8 polled mode, read side
    mrst_n = 0; flag_mode = 1; repeat (3) rtick();
    chk("R10 rd oe in reset", rd_bus_oe, 0);
    mrst_n = 1;
    for (int k = 0; k < 3*NG; k++) begin
      fill(k);
      if (k == 4) begin rd_strobe = 1; rd_addr = 4'd0; end
      if (k == 5) flag_mode = 0;   // R4: no effect after reset
      rtick(); rd_strobe = 0;
      chk("R8 rd poll grp", rd_grp, k % NG);
      chk("R8 rd poll bus", rd_bus_n, exp_rbus(k % NG));
      chk("R9 rd poll oe", rd_bus_oe, 1);
    end

    // R8 polled mode, write side
    mrst_n = 0; flag_mode = 1; repeat (3) wtick();
    mrst_n = 1;
    for (int k = 0; k < 3*NG; k++) begin
      fill(k + 2);
      if (k == 2) begin wr_strobe = 1; wr_addr = 4'd0; end
      wtick(); wr_strobe = 0;
      chk("R8 wr poll grp", wr_grp, k % NG);
      chk("R8 wr poll bus", wr_bus_n, exp_wbus(k % NG));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule